// File: doc/BRIEF.md
# Bounded-Regime Posit Unpacker

This block turns one packed posit word into the fields an arithmetic unit works on: a sign, one signed binary scale that merges the regime and exponent, a fraction with its hidden one made explicit, and flags for zero and for the not-a-real code. It is purely combinational, so a pipeline stage before or after it decides the timing. Negative words are turned into their magnitude by two's complement before any field is read.

The regime run is never longer than six bits, at any word width. Its length is therefore settled by looking only at the five bits after the sign. That look-up yields a one-hot code with one entry per possible regime length. The code steers a set of parallel multiplexers, one per length, that pick the exponent and fraction bits. No leading-run counter over the whole word and no variable shifter are needed. The total width and the exponent width are parameters. The exponent width defaults to five bits, which gives scales from -192 to 191.

Top module: `bposit_decoder`

## Requirements
- R1: The all-zero word raises `zero_o`, keeps `nar_o` low and drives `sign_o`, `scale_o` and `frac_o` to zero.
- R2: For a normal word, `scale_o` equals k·2^ES plus the unsigned exponent field. With ES=5 every result lies in -192..191.
- R3: Let b0 be the bit just below the sign, after negation. If the first bit that differs from b0 sits at offset 1, 2, 3 or 4 below b0, the regime is 2, 3, 4 or 5 bits long, counting the terminating bit.
- R4: If the five bits after the sign are all equal, the regime is exactly six bits. Six ones give k=5, five ones then a zero give k=4, six zeros give k=-6, and five zeros then a one give k=-5.
- R5: A run of m ones gives k=m-1 and a run of m zeros gives k=-m.
- R6: A word whose sign bit is 1 (and is neither zero nor NaR) decodes exactly like its two's complement, except that `sign_o` is 1.
- R7: The word with a 1 in the sign position and zeros elsewhere raises `nar_o`, keeps `zero_o` low and drives `sign_o`, `scale_o` and `frac_o` to zero. The two flags are never high together.
- R8: The exponent field is the ES bits directly below the regime.
- R9: `frac_o` is N-2-ES bits wide. Its MSB is a constant 1 for normal words. The fraction bits that follow the exponent are placed directly below that MSB, and any unused low positions are filled with zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | N | Packed posit word |
| sign_o | output | 1 | Sign of a normal word |
| scale_o | output | ES+4 | Signed power-of-two scale, regime and exponent merged |
| frac_o | output | N-2-ES | Hidden one followed by left-aligned fraction |
| zero_o | output | 1 | Word is exactly zero |
| nar_o | output | 1 | Word is the not-a-real code |

## Verification
The two functions that coincide most easily are the magnitude negation for negative words and the capped six-bit regime. A word such as 0x80000001 must first be negated into the largest positive magnitude and then decoded through the six-ones path. The bench drives such words from its vector table and compares every output field with hand-derived values. It then sweeps 64 generated words through both signs, requiring identical scale and fraction with only the sign output flipped. Zero and NaR sit one bit apart, so they are driven back to back, and each flag is checked to rise alone.

// File: rtl/bposit_pkg.sv
// bposit_pkg: shared constants and width helpers for the bounded-regime
// posit unpacker. Assumes the regime never exceeds six bits.
package bposit_pkg;
    localparam int unsigned REGIME_MAX = 6;
    localparam int unsigned SIZE_COUNT = 5;   // regime lengths 2..6
    localparam int unsigned PREFIX_BITS = 6;  // five look-up bits plus the sixth regime bit

    // width of the stored fraction for the shortest (2-bit) regime
    function automatic int unsigned frac_width(input int unsigned n, input int unsigned es);
        return n - 3 - es;
    endfunction

    // signed scale width: |k| <= 6 so k*2^es fits in es+4 bits
    function automatic int unsigned scale_width(input int unsigned es);
        return es + 4;
    endfunction
endpackage

// File: rtl/bposit_regime_scan.sv
// bposit_regime_scan: from the six leading magnitude bits below the sign,
// produces a one-hot regime-length code (entry j = length j+2) and the
// signed regime value k. Assumes the input is already a magnitude.
module bposit_regime_scan
    import bposit_pkg::*;
(
    input  logic [PREFIX_BITS-1:0] pfx_i,   // [5] is the bit right below the sign
    output logic [SIZE_COUNT-1:0]  size_oh_o,
    output logic signed [3:0]      k_o
);

    logic [PREFIX_BITS-1:0] p;     // p[0] = first regime bit
    logic [2:0]             run_len;

    // reverse into scan order so index equals offset below the sign
    always_comb begin
        for (int i = 0; i < PREFIX_BITS; i++) begin
            p[i] = pfx_i[PREFIX_BITS-1-i];
        end
    end

    // one-hot length: first mismatch among the next four bits, else capped
    always_comb begin
        logic same;
        same = 1'b1;
        for (int j = 0; j < SIZE_COUNT - 1; j++) begin
            size_oh_o[j] = same & (p[j+1] != p[0]);
            same         = same & (p[j+1] == p[0]);
        end
        size_oh_o[SIZE_COUNT-1] = same;
    end

    // run length: capped case may run through the sixth bit
    always_comb begin
        run_len = 3'd0;
        for (int j = 0; j < SIZE_COUNT - 1; j++) begin
            if (size_oh_o[j]) run_len = 3'(j + 1);
        end
        if (size_oh_o[SIZE_COUNT-1]) run_len = (p[5] == p[0]) ? 3'd6 : 3'd5;
    end

    // regime value from run polarity and length
    always_comb begin
        k_o = p[0] ? ($signed({1'b0, run_len}) - 4'sd1) : -$signed({1'b0, run_len});
    end

    // guard the length code and regime bounds
    always_comb begin
        assert_size_onehot_R3: assert ($countones(size_oh_o) == 1)
            else $error("regime length code not one-hot");
        assert_k_bounds_R4: assert (k_o >= -4'sd6 && k_o <= 4'sd5)
            else $error("regime value out of range");
    end

endmodule

// File: rtl/bposit_field_select.sv
// bposit_field_select: one candidate exponent/fraction slice per regime
// length, merged by AND-OR under the one-hot length code. Assumes
// N >= ES + 8 so the six-bit regime still leaves one fraction bit.
module bposit_field_select
    import bposit_pkg::*;
#(
    parameter int unsigned N  = 32,
    parameter int unsigned ES = 5
) (
    input  logic [N-4:0]             tail_i,    // magnitude below the first two regime bits
    input  logic [SIZE_COUNT-1:0]    size_oh_i,
    output logic [ES-1:0]            exp_o,
    output logic [frac_width(N,ES)-1:0] frac_o
);

    localparam int unsigned FW = frac_width(N, ES);

    logic [ES-1:0] cand_exp  [SIZE_COUNT];
    logic [FW-1:0] cand_frac [SIZE_COUNT];

    for (genvar j = 0; j < SIZE_COUNT; j++) begin : g_len
        localparam int unsigned XTRA = j;            // regime bits beyond two
        localparam int unsigned FB   = FW - XTRA;    // fraction bits present
        // slice for regime length j+2
        always_comb begin
            cand_exp[j]  = tail_i[N-4-XTRA -: ES];
            cand_frac[j] = FW'(tail_i[FB-1:0]) << XTRA;
        end
    end

    // merge candidates under the one-hot code
    always_comb begin
        exp_o  = '0;
        frac_o = '0;
        for (int j = 0; j < SIZE_COUNT; j++) begin
            exp_o  = exp_o  | (cand_exp[j]  & {ES{size_oh_i[j]}});
            frac_o = frac_o | (cand_frac[j] & {FW{size_oh_i[j]}});
        end
    end

    // longer regimes leave trailing pad bits that must be zero
    always_comb begin
        for (int j = 1; j < SIZE_COUNT; j++) begin
            if (size_oh_i[j]) begin
                assert_frac_pad_R9: assert ((frac_o & FW'((1 << j) - 1)) == '0)
                    else $error("fraction pad bits not zero");
            end
        end
    end

endmodule

// File: rtl/bposit_decoder.sv
// bposit_decoder: top of the bounded-regime posit unpacker. Negates
// negative words, finds the regime length from a short prefix, selects
// fields by multiplexer and merges regime and exponent into one scale.
// Purely combinational. Assumes N > 12 and N >= ES + 8.
module bposit_decoder
    import bposit_pkg::*;
#(
    parameter int unsigned N  = 32,
    parameter int unsigned ES = 5
) (
    input  logic [N-1:0]                   word_i,
    output logic                           sign_o,
    output logic signed [ES+3:0]           scale_o,
    output logic [N-3-ES:0]                frac_o,
    output logic                           zero_o,
    output logic                           nar_o
);

    localparam int unsigned FW  = frac_width(N, ES);
    localparam int unsigned SCW = scale_width(ES);

    logic [N-2:0]            body;
    logic [SIZE_COUNT-1:0]   size_oh;
    logic signed [3:0]       k_val;
    logic [ES-1:0]           exp_fld;
    logic [FW-1:0]           frac_fld;
    logic signed [SCW-1:0]   scale_raw;
    logic                    special;

    // magnitude below the sign bit
    always_comb begin
        body = word_i[N-1] ? (~word_i[N-2:0] + 1'b1) : word_i[N-2:0];
    end

    bposit_regime_scan u_scan (
        .pfx_i     (body[N-2 -: PREFIX_BITS]),
        .size_oh_o (size_oh),
        .k_o       (k_val)
    );

    bposit_field_select #(.N(N), .ES(ES)) u_fields (
        .tail_i    (body[N-4:0]),
        .size_oh_i (size_oh),
        .exp_o     (exp_fld),
        .frac_o    (frac_fld)
    );

    // special-word detection
    always_comb begin
        zero_o  = (word_i == '0);
        nar_o   = word_i[N-1] & ~(|word_i[N-2:0]);
        special = zero_o | nar_o;
    end

    // merge regime value and exponent into one scale
    always_comb begin
        scale_raw = (SCW'(k_val) <<< ES) + SCW'($signed({1'b0, exp_fld}));
    end

    // final outputs, cleared for the special words
    always_comb begin
        sign_o  = word_i[N-1] & ~special;
        scale_o = special ? '0 : scale_raw;
        frac_o  = special ? '0 : {1'b1, frac_fld};
    end

    // guard flag exclusivity, special clearing and scale bounds
    always_comb begin
        assert_flags_exclusive_R7: assert (!(zero_o && nar_o))
            else $error("zero and NaR flags together");
        if (zero_o || nar_o) begin
            assert_special_clear_R1: assert (!sign_o && scale_o == '0 && frac_o == '0)
                else $error("special word left nonzero fields");
        end
        assert_scale_bounds_R2: assert (int'(scale_o) >= -(6 <<< ES) && int'(scale_o) < (6 <<< ES))
            else $error("scale outside bounded range");
    end

endmodule

// File: tb/tb_bposit_decoder.sv
// tb_bposit_decoder: vector table walk, then directed reset, special-word
// and sign-symmetry tests for the 32-bit, ES=5 configuration.
module tb_bposit_decoder;

    localparam int N  = 32;
    localparam int ES = 5;
    localparam int FW = N - 2 - ES;   // frac_o width, 25
    localparam int SW = ES + 4;       // scale width, 9

    typedef struct packed {
        logic [N-1:0]         w;
        logic                 s;
        logic signed [SW-1:0] sc;
        logic [FW-1:0]        f;
        logic                 z;
        logic                 n;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{32'h40000000, 1'b0,  9'sd0,   25'h1000000, 1'b0, 1'b0}, // R2 R3 one
        '{32'h48000000, 1'b0,  9'sd8,   25'h1000000, 1'b0, 1'b0}, // R8 exponent 8
        '{32'h40800001, 1'b0,  9'sd0,   25'h1800001, 1'b0, 1'b0}, // R9 full fraction
        '{32'h20000000, 1'b0, -9'sd32,  25'h1000000, 1'b0, 1'b0}, // R5 k=-1
        '{32'h60000000, 1'b0,  9'sd32,  25'h1000000, 1'b0, 1'b0}, // R3 length 3
        '{32'h60000001, 1'b0,  9'sd32,  25'h1000002, 1'b0, 1'b0}, // R9 pad one
        '{32'h71234567, 1'b0,  9'sd68,  25'h18D159C, 1'b0, 1'b0}, // R3 R8 R9 length 4
        '{32'h08000000, 1'b0, -9'sd96,  25'h1000000, 1'b0, 1'b0}, // R5 k=-3
        '{32'h7BE00000, 1'b0,  9'sd127, 25'h1000000, 1'b0, 1'b0}, // R3 R8 length 5
        '{32'h7E000000, 1'b0,  9'sd160, 25'h1000000, 1'b0, 1'b0}, // R4 six ones
        '{32'h7FFFFFFF, 1'b0,  9'sd191, 25'h1FFFFF0, 1'b0, 1'b0}, // R4 R2 max scale
        '{32'h7C000000, 1'b0,  9'sd128, 25'h1000000, 1'b0, 1'b0}, // R4 five ones then zero
        '{32'h00000001, 1'b0, -9'sd192, 25'h1000010, 1'b0, 1'b0}, // R4 R2 min scale
        '{32'h02000000, 1'b0, -9'sd160, 25'h1000000, 1'b0, 1'b0}, // R4 five zeros then one
        '{32'hC0000000, 1'b1,  9'sd0,   25'h1000000, 1'b0, 1'b0}, // R6 minus one
        '{32'hB8000000, 1'b1,  9'sd8,   25'h1000000, 1'b0, 1'b0}, // R6 negated exponent
        '{32'h80000001, 1'b1,  9'sd191, 25'h1FFFFF0, 1'b0, 1'b0}, // R6 R4 negate into cap
        '{32'hFFFFFFFF, 1'b1, -9'sd192, 25'h1000010, 1'b0, 1'b0}, // R6 R4 negative minimum
        '{32'h00000000, 1'b0,  9'sd0,   25'h0000000, 1'b1, 1'b0}, // R1 zero
        '{32'h80000000, 1'b0,  9'sd0,   25'h0000000, 1'b0, 1'b1}  // R7 NaR
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         word_i = '0;
    logic                 sign_o;
    logic signed [SW-1:0] scale_o;
    logic [FW-1:0]        frac_o;
    logic                 zero_o;
    logic                 nar_o;
    int                   total = 0;
    int                   bad = 0;
    logic                 done = 1'b0;

    bposit_decoder #(.N(N), .ES(ES)) dut (
        .word_i  (word_i),
        .sign_o  (sign_o),
        .scale_o (scale_o),
        .frac_o  (frac_o),
        .zero_o  (zero_o),
        .nar_o   (nar_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    // record one comparison
    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // apply a word away from the clock edge and let it settle
    task automatic drive(input logic [N-1:0] w);
        @(negedge clk);
        word_i = w;
        #1;
    endtask

    initial begin
        logic [N-1:0] w;
        logic signed [SW-1:0] sc_p;
        logic [FW-1:0] f_p;

        // reset state: input held at zero
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset zero flag", 64'(zero_o), 64'd1);
        chk("R1 reset fields", 64'({sign_o, scale_o, frac_o, nar_o}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].w);
            chk($sformatf("R1-9 vector %0d word %h", i, TBL[i].w),
                64'({sign_o, scale_o, frac_o, zero_o, nar_o}),
                64'({TBL[i].s, TBL[i].sc, TBL[i].f, TBL[i].z, TBL[i].n}));
        end

        // zero and NaR back to back, each flag alone
        drive(32'h80000000);
        chk("R7 NaR flag alone", 64'({zero_o, nar_o}), 64'b01);
        drive(32'h00000000);
        chk("R1 zero flag alone", 64'({zero_o, nar_o}), 64'b10);
        drive(32'h80000000);
        chk("R7 NaR fields cleared", 64'({sign_o, scale_o, frac_o}), 64'd0);

        // sign symmetry sweep: negative words match their magnitude
        for (int i = 1; i <= 64; i++) begin
            w = 32'(i) * 32'h9E3779B1;
            w[N-1] = 1'b0;
            if (w == '0) w = 32'h1;
            drive(w);
            sc_p = scale_o;
            f_p  = frac_o;
            chk("R6 positive sign", 64'(sign_o), 64'd0);
            drive(~w + 1'b1);
            chk("R6 negated fields", 64'({sign_o, scale_o, frac_o}), 64'({1'b1, sc_p, f_p}));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule